// File: doc/BRIEF.md
# Dual-Channel Triangle-Wave DAC Data Path

This block is the digital front end of a two-channel converter. Each channel keeps a 12-bit held value and a free-running up/down triangle counter whose peak is programmed by a 4-bit amplitude code. When a channel is enabled and the trigger line it selects is high at a rising clock edge, the block computes held value plus counter, modulo 4096. That sum lands in the channel's output register exactly three clock edges later, and the counter takes one step on that same edge.

The two channels are configured separately: trigger enable, trigger source, wave mode and amplitude. Pointing both selects at the same source makes the channels update together, each with its own amplitude. One shared write port loads both held values at once, in a right-aligned 12-bit, left-aligned 12-bit or right-aligned 8-bit layout. The external reset is asynchronous and active low. Its release is synchronised inside the block over two clock edges.

Top module: `dual_tri_dac_path`

## Requirements
- R1: While reset is active and after it releases, both output registers, both held values and both triangle counters are zero.
- R2: A channel whose trigger enable is 0 ignores every trigger, and its output keeps its value.
- R3: A channel starts a transfer when its enable is 1, the trigger line indexed by its 3-bit select is high at a rising edge, and no transfer of its own is pending. A line that is not selected has no effect. Equal selects make both channels update on the same edge.
- R4: For amplitude code n, the triangle peak is 2^(n+1)-1, and codes 11 to 15 give 4095. The counter starts at 0, steps up by one per transfer until it reaches the peak, then steps down by one to 0, and repeats.
- R5: The output becomes held value plus counter (12-bit, wrapping modulo 4096), both sampled at the trigger edge. It changes on the third rising edge after that edge, and on no other edge.
- R6: The counter steps on the edge that writes the output, so each trigger uses the counter value from before its own step. At all other times the counter is stable.
- R7: A wave-mode field of 2'b10 or 2'b11 enables the triangle. Any other value adds 0 to the held value and clears the counter to 0 and its direction to up from the next edge.
- R8: A trigger that arrives on any of the three edges after an accepted trigger, while that channel's transfer is pending, is ignored and does not step the counter.
- R9: A dual write loads both held values on the write edge. Format 0 uses channel 1 = data[11:0] and channel 2 = data[27:16]. Format 1 uses [15:4] and [31:20]. Format 2 uses {data[7:0],4'h0} and {data[15:8],4'h0}. Format 3 leaves both held values unchanged.
- R10: Two channels on a shared trigger with different amplitude codes each follow their own triangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_src | input | NUM_TRIG | Trigger lines, sampled at each rising edge |
| c1_trig_en | input | 1 | Channel 1 trigger enable |
| c1_trig_sel | input | SEL_W | Channel 1 trigger line index |
| c1_wave | input | 2 | Channel 1 wave mode (1x = triangle) |
| c1_amp | input | 4 | Channel 1 amplitude code |
| c2_trig_en | input | 1 | Channel 2 trigger enable |
| c2_trig_sel | input | SEL_W | Channel 2 trigger line index |
| c2_wave | input | 2 | Channel 2 wave mode (1x = triangle) |
| c2_amp | input | 4 | Channel 2 amplitude code |
| dual_wr_en | input | 1 | Dual held-value write strobe |
| dual_wr_fmt | input | 2 | Dual write layout (0, 1, 2, 3 = none) |
| dual_wr_data | input | 32 | Dual write data |
| c1_dout | output | 12 | Channel 1 output data register |
| c2_dout | output | 12 | Channel 2 output data register |

## Verification
A trigger sampled at edge k appears on the outputs after edge k+3. The bench therefore drives the trigger at a falling edge, waits through that rising edge and three more, and samples at the next falling edge. One directed case also samples after edge k+2, to show the old value is still present. A dual write takes effect after the one edge that latches it. A change of wave mode clears the counter after one edge. A bench model of the held values, outputs and counters, built from the requirements, gives the expected value of every sample. A long run at a clamped amplitude covers the 4095 peak, the turn back down and the wrapping sum.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int DW     = 12;  // held/output data width
  localparam int AMP_W  = 4;   // amplitude code width
  localparam int BUS_W  = 32;  // dual write bus width
  localparam int HALF_W = BUS_W / 2;
  localparam int LSH_W  = HALF_W - DW;  // left-aligned offset
  localparam int NARW_W = DW - LSH_W;   // narrow format width

  typedef enum logic [1:0] {
    FMT_R12  = 2'd0,
    FMT_L12  = 2'd1,
    FMT_R8   = 2'd2,
    FMT_NONE = 2'd3
  } wr_fmt_e;

  // Triangle peak for an amplitude code: 2^(n+1)-1, clamped to all ones.
  function automatic logic [DW-1:0] peak_of(input logic [AMP_W-1:0] code);
    logic [DW-1:0] pk;
    if (int'(code) >= DW - 1) pk = '1;
    else                      pk = {DW{1'b1}} >> (DW - 1 - int'(code));
    return pk;
  endfunction
endpackage

// File: rtl/dtw_write_unpack.sv
module dtw_write_unpack
  import dtw_pkg::*;
(
  input  logic             wr_en,
  input  logic [1:0]       wr_fmt,
  input  logic [BUS_W-1:0] wr_data,
  output logic             ld,
  output logic [DW-1:0]    val_a,
  output logic [DW-1:0]    val_b
);
  always_comb begin
    ld    = 1'b0;
    val_a = '0;
    val_b = '0;
    case (wr_fmt_e'(wr_fmt))
      FMT_R12: begin
        ld    = wr_en;
        val_a = wr_data[DW-1:0];
        val_b = wr_data[HALF_W+DW-1:HALF_W];
      end
      FMT_L12: begin
        ld    = wr_en;
        val_a = wr_data[HALF_W-1:LSH_W];
        val_b = wr_data[BUS_W-1:HALF_W+LSH_W];
      end
      FMT_R8: begin
        ld    = wr_en;
        val_a = {wr_data[NARW_W-1:0], {LSH_W{1'b0}}};
        val_b = {wr_data[2*NARW_W-1:NARW_W], {LSH_W{1'b0}}};
      end
      default: ld = 1'b0;
    endcase
  end
endmodule

// File: rtl/dtw_ramp_counter.sv
module dtw_ramp_counter
  import dtw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ramp_on,
  input  logic             step,
  input  logic [AMP_W-1:0] amp,
  output logic [DW-1:0]    ramp
);
  logic [DW-1:0] ramp_q, ramp_d, pk;
  logic          up_q, up_d, ce;

  assign pk = peak_of(amp);
  assign ce = !ramp_on || step;

  always_comb begin
    ramp_d = ramp_q;
    up_d   = up_q;
    if (!ramp_on) begin
      ramp_d = '0;
      up_d   = 1'b1;
    end else if (up_q) begin
      if (ramp_q >= pk) begin
        up_d   = 1'b0;
        ramp_d = ramp_q - 1'b1;
      end else begin
        ramp_d = ramp_q + 1'b1;
      end
    end else if (ramp_q == '0) begin
      up_d   = 1'b1;
      ramp_d = ramp_q + 1'b1;
    end else begin
      ramp_d = ramp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      up_q   <= 1'b1;
    end else if (ce) begin
      ramp_q <= ramp_d;
      up_q   <= up_d;
    end
  end

  assign ramp = ramp_q;
endmodule

// File: rtl/dtw_channel.sv
module dtw_channel
  import dtw_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int XFER_DLY = 3,
  localparam int SEL_W   = $clog2(NUM_TRIG),
  localparam int CW      = $clog2(XFER_DLY + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_vec,
  input  logic                trig_en,
  input  logic [SEL_W-1:0]    trig_sel,
  input  logic [1:0]          wave,
  input  logic [AMP_W-1:0]    amp,
  input  logic                ld,
  input  logic [DW-1:0]       ld_val,
  output logic [DW-1:0]       dout,
  output logic                start,
  output logic                xfer,
  output logic                ramp_on,
  output logic [DW-1:0]       ramp
);
  logic [DW-1:0] held_q, sum_q, sum_d, dout_q, ramp_eff;
  logic [CW-1:0] rem_q, rem_d;
  logic          busy;

  assign ramp_on  = (wave == 2'b10) || (wave == 2'b11);
  assign busy     = (rem_q != '0);
  assign start    = trig_en && trig_vec[trig_sel] && !busy;
  assign xfer     = (rem_q == CW'(1));
  assign ramp_eff = ramp_on ? ramp : '0;
  assign sum_d    = held_q + ramp_eff;

  always_comb begin
    rem_d = rem_q;
    if (start)     rem_d = CW'(XFER_DLY);
    else if (busy) rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      sum_q  <= '0;
      dout_q <= '0;
      rem_q  <= '0;
    end else begin
      rem_q <= rem_d;
      if (ld)    held_q <= ld_val;
      if (start) sum_q  <= sum_d;
      if (xfer)  dout_q <= sum_q;
    end
  end

  dtw_ramp_counter u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ramp_on (ramp_on),
    .step    (xfer),
    .amp     (amp),
    .ramp    (ramp)
  );

  assign dout = dout_q;
endmodule

// File: rtl/dual_tri_dac_path.sv
module dual_tri_dac_path
  import dtw_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int XFER_DLY = 3,
  localparam int SEL_W   = $clog2(NUM_TRIG),
  localparam int NCH     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_src,
  input  logic                c1_trig_en,
  input  logic [SEL_W-1:0]    c1_trig_sel,
  input  logic [1:0]          c1_wave,
  input  logic [AMP_W-1:0]    c1_amp,
  input  logic                c2_trig_en,
  input  logic [SEL_W-1:0]    c2_trig_sel,
  input  logic [1:0]          c2_wave,
  input  logic [AMP_W-1:0]    c2_amp,
  input  logic                dual_wr_en,
  input  logic [1:0]          dual_wr_fmt,
  input  logic [BUS_W-1:0]    dual_wr_data,
  output logic [DW-1:0]       c1_dout,
  output logic [DW-1:0]       c2_dout
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                      ld;
  logic [NCH-1:0][DW-1:0]    ldv_a, dout_a, ramp_a;
  logic [NCH-1:0]            en_a, start_a, xfer_a, on_a;
  logic [NCH-1:0][SEL_W-1:0] sel_a;
  logic [NCH-1:0][1:0]       wave_a;
  logic [NCH-1:0][AMP_W-1:0] amp_a;

  assign en_a   = {c2_trig_en, c1_trig_en};
  assign sel_a  = {c2_trig_sel, c1_trig_sel};
  assign wave_a = {c2_wave, c1_wave};
  assign amp_a  = {c2_amp, c1_amp};

  dtw_write_unpack u_unpack (
    .wr_en   (dual_wr_en),
    .wr_fmt  (dual_wr_fmt),
    .wr_data (dual_wr_data),
    .ld      (ld),
    .val_a   (ldv_a[0]),
    .val_b   (ldv_a[1])
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dtw_channel #(
      .NUM_TRIG (NUM_TRIG),
      .XFER_DLY (XFER_DLY)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .trig_vec (trig_src),
      .trig_en  (en_a[i]),
      .trig_sel (sel_a[i]),
      .wave     (wave_a[i]),
      .amp      (amp_a[i]),
      .ld       (ld),
      .ld_val   (ldv_a[i]),
      .dout     (dout_a[i]),
      .start    (start_a[i]),
      .xfer     (xfer_a[i]),
      .ramp_on  (on_a[i]),
      .ramp     (ramp_a[i])
    );
  end

  assign c1_dout = dout_a[0];
  assign c2_dout = dout_a[1];
endmodule

// File: rtl/dual_tri_dac_path_chk.sv
module dual_tri_dac_path_chk
  import dtw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         start,
  input logic [1:0]         xfer,
  input logic [1:0]         ramp_on,
  input logic [1:0][DW-1:0] ramp,
  input logic [1:0][DW-1:0] dout
);
  for (genvar i = 0; i < 2; i++) begin : g_prop
    // R5: the output register is written exactly three edges after a start
    p_xfer_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] |=> !xfer[i] ##1 !xfer[i] ##1 xfer[i]);
    // R5: no write edge, no change at the output
    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer[i] |=> $stable(dout[i]));
    // R8: no second start while a transfer is pending
    p_one_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] |=> !start[i] ##1 !start[i] ##1 !start[i]);
    // R6: the counter moves by exactly one on a write edge
    p_ramp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer[i] && ramp_on[i]) |=>
        (ramp[i] == $past(ramp[i]) + 1'b1) || (ramp[i] == $past(ramp[i]) - 1'b1));
    // R6: the counter does not move between write edges
    p_ramp_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer[i] && ramp_on[i]) |=> $stable(ramp[i]));
    // R7: triangle off clears the counter
    p_wave_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ramp_on[i] |=> (ramp[i] == '0));
  end
endmodule

bind dual_tri_dac_path dual_tri_dac_path_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start   (start_a),
  .xfer    (xfer_a),
  .ramp_on (on_a),
  .ramp    (ramp_a),
  .dout    (dout_a)
);

// File: tb/dual_tri_dac_path_bench.sv
`timescale 1ns/1ps
module dual_tri_dac_path_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  trig_src;
  logic        c1_trig_en, c2_trig_en;
  logic [2:0]  c1_trig_sel, c2_trig_sel;
  logic [1:0]  c1_wave, c2_wave;
  logic [3:0]  c1_amp, c2_amp;
  logic        dual_wr_en;
  logic [1:0]  dual_wr_fmt;
  logic [31:0] dual_wr_data;
  logic [11:0] c1_dout, c2_dout;

  int checks = 0;
  int errors = 0;

  logic [11:0] m_held [2];
  logic [11:0] m_out  [2];
  logic [11:0] m_ramp [2];
  bit          m_up   [2];

  always #10 clk = ~clk;  // 50 MHz

  dual_tri_dac_path u_dual_tri_dac_path (
    .clk(clk), .rst_n(rst_n), .trig_src(trig_src),
    .c1_trig_en(c1_trig_en), .c1_trig_sel(c1_trig_sel), .c1_wave(c1_wave), .c1_amp(c1_amp),
    .c2_trig_en(c2_trig_en), .c2_trig_sel(c2_trig_sel), .c2_wave(c2_wave), .c2_amp(c2_amp),
    .dual_wr_en(dual_wr_en), .dual_wr_fmt(dual_wr_fmt), .dual_wr_data(dual_wr_data),
    .c1_dout(c1_dout), .c2_dout(c2_dout)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] peak_m(input logic [3:0] a);
    if (a >= 4'd11) return 12'hFFF;
    return 12'((1 << (a + 1)) - 1);
  endfunction

  function automatic bit tri_on(input logic [1:0] w);
    return w[1];
  endfunction

  task automatic adv(input int ch, input logic [3:0] a);
    if (m_up[ch]) begin
      if (m_ramp[ch] >= peak_m(a)) begin m_up[ch] = 1'b0; m_ramp[ch] = m_ramp[ch] - 1; end
      else m_ramp[ch] = m_ramp[ch] + 1;
    end else begin
      if (m_ramp[ch] == 0) begin m_up[ch] = 1'b1; m_ramp[ch] = m_ramp[ch] + 1; end
      else m_ramp[ch] = m_ramp[ch] - 1;
    end
  endtask

  task automatic set_wave(input logic [1:0] w1, input logic [1:0] w2);
    @(negedge clk);
    c1_wave = w1; c2_wave = w2;
    @(negedge clk);
    if (!tri_on(w1)) begin m_ramp[0] = '0; m_up[0] = 1'b1; end
    if (!tri_on(w2)) begin m_ramp[1] = '0; m_up[1] = 1'b1; end
  endtask

  task automatic dual_write(input logic [1:0] fmt, input logic [31:0] d);
    @(negedge clk);
    dual_wr_en = 1'b1; dual_wr_fmt = fmt; dual_wr_data = d;
    @(negedge clk);
    dual_wr_en = 1'b0;
    case (fmt)
      2'd0: begin m_held[0] = d[11:0];  m_held[1] = d[27:16]; end
      2'd1: begin m_held[0] = d[15:4];  m_held[1] = d[31:20]; end
      2'd2: begin m_held[0] = {d[7:0], 4'h0}; m_held[1] = {d[15:8], 4'h0}; end
      default: ;
    endcase
  endtask

  // One trigger pulse, results sampled after the third following edge.
  task automatic fire(input logic [7:0] mask, input string tag);
    logic [11:0] e1, e2;
    bit r1, r2;
    r1 = c1_trig_en && mask[c1_trig_sel];
    r2 = c2_trig_en && mask[c2_trig_sel];
    e1 = r1 ? 12'(m_held[0] + (tri_on(c1_wave) ? m_ramp[0] : 12'd0)) : m_out[0];
    e2 = r2 ? 12'(m_held[1] + (tri_on(c2_wave) ? m_ramp[1] : 12'd0)) : m_out[1];
    @(negedge clk) trig_src = mask;
    @(posedge clk);
    @(negedge clk) trig_src = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(c1_dout == e1, {tag, " ch1"}, c1_dout, e1);
    check(c2_dout == e2, {tag, " ch2"}, c2_dout, e2);
    if (r1) begin m_out[0] = e1; if (tri_on(c1_wave)) adv(0, c1_amp); end
    if (r2) begin m_out[1] = e2; if (tri_on(c2_wave)) adv(1, c2_amp); end
  endtask

  task automatic t_reset;
    check(c1_dout == 12'h000, "R1 reset ch1", c1_dout, 0);
    check(c2_dout == 12'h000, "R1 reset ch2", c2_dout, 0);
    fire(8'h01, "R1 zero held and counter");
  endtask

  task automatic t_formats;
    dual_write(2'd0, 32'h0ABC_0123); fire(8'h01, "R9 format 0");
    dual_write(2'd1, 32'hDEF0_4560); fire(8'h01, "R9 format 1");
    dual_write(2'd2, 32'h0000_A55A); fire(8'h01, "R9 format 2");
    dual_write(2'd3, 32'h1234_5678); fire(8'h01, "R9 format 3 ignored");
  endtask

  task automatic t_latency;
    logic [11:0] old1;
    old1 = m_out[0];
    dual_write(2'd0, 32'h0222_0111);
    @(negedge clk) trig_src = 8'h01;
    @(posedge clk);
    @(negedge clk) trig_src = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(c1_dout == old1, "R5 not yet at edge k+2", c1_dout, old1);
    @(posedge clk);
    @(negedge clk);
    check(c1_dout == 12'h111, "R5 due at edge k+3", c1_dout, 12'h111);
    m_out[0] = 12'h111; m_out[1] = 12'h222;
  endtask

  task automatic t_enable;
    c1_trig_en = 1'b0;
    dual_write(2'd0, 32'h0444_0333);
    fire(8'h01, "R2 disabled channel");
    c1_trig_en = 1'b1;
  endtask

  task automatic t_select;
    c1_trig_sel = 3'd2; c2_trig_sel = 3'd5;
    dual_write(2'd0, 32'h0666_0555);
    fire(8'h20, "R3 only line 5");
    fire(8'h04, "R3 only line 2");
    dual_write(2'd0, 32'h0888_0777);
    fire(8'h01, "R3 unselected line");
    c1_trig_sel = 3'd3; c2_trig_sel = 3'd3;
    fire(8'h08, "R3 shared line");
  endtask

  task automatic t_triangle;
    c1_amp = 4'd1; c2_amp = 4'd0;
    set_wave(2'b10, 2'b11);
    dual_write(2'd0, 32'h00C8_0064);
    for (int n = 0; n < 10; n++) fire(8'h08, "R4 R6 R10 triangle walk");
  endtask

  task automatic t_retrig;
    @(negedge clk) trig_src = 8'h08;
    repeat (4) @(posedge clk);
    @(negedge clk) trig_src = '0;
    m_out[0] = 12'(m_held[0] + m_ramp[0]); adv(0, c1_amp);
    m_out[1] = 12'(m_held[1] + m_ramp[1]); adv(1, c2_amp);
    check(c1_dout == m_out[0], "R8 held trigger ch1", c1_dout, m_out[0]);
    check(c2_dout == m_out[1], "R8 held trigger ch2", c2_dout, m_out[1]);
    fire(8'h08, "R8 counter stepped once");
  endtask

  task automatic t_wave_off;
    set_wave(2'b00, 2'b01);
    fire(8'h08, "R7 wave off adds zero");
    set_wave(2'b10, 2'b10);
    fire(8'h08, "R7 counter restarts at 0");
  endtask

  task automatic t_clamp;
    c1_amp = 4'd15; c2_amp = 4'd12;
    set_wave(2'b00, 2'b00);
    set_wave(2'b10, 2'b10);
    dual_write(2'd0, 32'h0100_0FF0);
    for (int n = 0; n < 4100; n++) fire(8'h08, "R4 clamped peak R5 wrap");
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trig_src = '0;
    c1_trig_en = 1'b1; c2_trig_en = 1'b1;
    c1_trig_sel = 3'd0; c2_trig_sel = 3'd0;
    c1_wave = 2'b00; c2_wave = 2'b00;
    c1_amp = 4'd0; c2_amp = 4'd0;
    dual_wr_en = 1'b0; dual_wr_fmt = 2'd0; dual_wr_data = '0;
    for (int c = 0; c < 2; c++) begin
      m_held[c] = '0; m_out[c] = '0; m_ramp[c] = '0; m_up[c] = 1'b1;
    end
    repeat (3) @(negedge clk);
    check(c1_dout == 12'h000, "R1 in reset", c1_dout, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_formats();
    t_latency();
    t_enable();
    t_select();
    t_triangle();
    t_retrig();
    t_wave_off();
    t_clamp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule